// File: doc/BRIEF.md
# GPIO Expander Register Bank

This block is the register core of an 8-bit general-purpose I/O expander. A bus front end presents a command pointer together with a write strobe and write data. The block answers with the read data of the selected register. It holds four registers behind that pointer: a read-only sampled-input register, an output-value register, a per-bit polarity-inversion mask and a direction register.

External pin levels enter through a two-flop synchroniser. The synchronised value is always visible at pointer 0x00, whatever each pin's direction. The read passes through the inversion mask. The direction register turns each pin's driver on or off, and the output register supplies the level driven on every pin whose driver is on.

Top module: `gpx_bank`

## Requirements
- R1: A synchronous active-high reset sets the output register to all ones, the polarity mask to all zeros and the direction register to all ones. The synchroniser flops reset to all ones. After reset, `pin_oe` is 0x00 and `pin_out` is 0xFF.
- R2: Reading pointer 0x00 returns each synchronised pin bit XORed with the matching polarity-mask bit (mask bit 1 = inverted).
- R3: A write to pointer 0x00 is discarded. The input read, `pin_out` and `pin_oe` are unchanged afterwards.
- R4: Pointers 0x01 (output), 0x02 (polarity) and 0x03 (direction) are writable. A write on one clock edge is returned by a read of the same pointer from the next cycle on.
- R5: `pin_oe[i]` is the inverse of direction bit i, where 1 = input with the driver off and 0 = driver on. `pin_out` equals the output register at all times.
- R6: The input register follows the pin level even when the pin is configured as a driven output.
- R7: A change on `pin_in` becomes visible at pointer 0x00 after exactly two rising clock edges.
- R8: For any pointer above 0x03, writes change nothing and reads return 0x00.
- R9: The polarity mask affects only reads of pointer 0x00. It never alters `pin_out` or reads of pointers 0x01 to 0x03.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| srst | input | 1 | Synchronous active-high reset |
| ptr | input | 8 | Command pointer selecting a register |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 8 | Data to write |
| rd_data | output | 8 | Combinational read of the selected register |
| pin_in | input | 8 | Asynchronous pin levels |
| pin_out | output | 8 | Output level for each pin |
| pin_oe | output | 8 | Driver enable for each pin, 1 = driven |

## Verification
The hardest case to reach from the ports is a pin that is driven as an output while the outside world pulls it to a different level. In that case the input register must show the external level, not the driven one. The stimulus clears the direction register, loads an output pattern, and then forces `pin_in` to its complement while reading pointer 0x00 with and without a polarity mask. A cycle-accurate model in the bench tracks the two-edge synchroniser delay, so every cycle of a pin change is compared.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
    localparam int PTR_W = 8;

    typedef logic [PTR_W-1:0] ptr_t;

    typedef enum logic [1:0] {
        SEL_IN  = 2'd0,
        SEL_OUT = 2'd1,
        SEL_POL = 2'd2,
        SEL_DIR = 2'd3
    } sel_e;

    typedef struct packed {
        logic hit;
        sel_e sel;
    } dec_t;

    function automatic dec_t decode_ptr(ptr_t p);
        dec_t d;
        d.hit = (p < ptr_t'(4));
        d.sel = sel_e'(p[1:0]);
        return d;
    endfunction
endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         srst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (srst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '1;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gpx_regs.sv
module gpx_regs #(
    parameter int W = 8
) (
    input  logic          clk,
    input  logic          srst,
    input  gpx_pkg::dec_t wdec,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_data,
    output logic [W-1:0]  out_q,
    output logic [W-1:0]  pol_q,
    output logic [W-1:0]  dir_q
);
    import gpx_pkg::*;

    logic wr_ok;
    assign wr_ok = wr_en && wdec.hit;

    always_ff @(posedge clk) begin
        if (srst) begin
            out_q <= '1;
            pol_q <= '0;
            dir_q <= '1;
        end else if (wr_ok) begin
            case (wdec.sel)
                SEL_OUT: out_q <= wr_data;
                SEL_POL: pol_q <= wr_data;
                SEL_DIR: dir_q <= wr_data;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/gpx_rdmux.sv
module gpx_rdmux #(
    parameter int W = 8
) (
    input  gpx_pkg::dec_t rdec,
    input  logic [W-1:0]  pins_s,
    input  logic [W-1:0]  out_q,
    input  logic [W-1:0]  pol_q,
    input  logic [W-1:0]  dir_q,
    output logic [W-1:0]  rd_data
);
    import gpx_pkg::*;

    always_comb begin
        rd_data = '0;
        if (rdec.hit) begin
            unique case (rdec.sel)
                SEL_IN:  rd_data = pins_s ^ pol_q;
                SEL_OUT: rd_data = out_q;
                SEL_POL: rd_data = pol_q;
                SEL_DIR: rd_data = dir_q;
            endcase
        end
    end
endmodule

// File: rtl/gpx_bank.sv
module gpx_bank #(
    parameter int W           = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  srst,
    input  logic [gpx_pkg::PTR_W-1:0] ptr,
    input  logic                  wr_en,
    input  logic [W-1:0]          wr_data,
    output logic [W-1:0]          rd_data,
    input  logic [W-1:0]          pin_in,
    output logic [W-1:0]          pin_out,
    output logic [W-1:0]          pin_oe
);
    import gpx_pkg::*;

    dec_t         dec;
    logic [W-1:0] pins_s;
    logic [W-1:0] out_q, pol_q, dir_q;

    assign dec = decode_ptr(ptr);

    gpx_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .srst(srst),
        .d   (pin_in),
        .q   (pins_s)
    );

    gpx_regs #(.W(W)) u_regs (
        .clk    (clk),
        .srst   (srst),
        .wdec   (dec),
        .wr_en  (wr_en),
        .wr_data(wr_data),
        .out_q  (out_q),
        .pol_q  (pol_q),
        .dir_q  (dir_q)
    );

    gpx_rdmux #(.W(W)) u_rdmux (
        .rdec   (dec),
        .pins_s (pins_s),
        .out_q  (out_q),
        .pol_q  (pol_q),
        .dir_q  (dir_q),
        .rd_data(rd_data)
    );

    assign pin_out = out_q;
    assign pin_oe  = ~dir_q;
endmodule

// File: rtl/gpx_bank_chk.sv
module gpx_bank_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         srst,
    input logic [7:0]   ptr,
    input logic         wr_en,
    input logic [W-1:0] wr_data,
    input logic [W-1:0] rd_data,
    input logic [W-1:0] pin_out,
    input logic [W-1:0] pin_oe
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        srst |=> (pin_oe == '0) && (pin_out == '1));

    // R4
    out_write_chk: assert property (@(posedge clk) disable iff (srst)
        (wr_en && ptr == 8'd1) |=> pin_out == $past(wr_data));

    // R5
    dir_write_chk: assert property (@(posedge clk) disable iff (srst)
        (wr_en && ptr == 8'd3) |=> pin_oe == ~$past(wr_data));

    // R8
    hole_read_chk: assert property (@(posedge clk) disable iff (srst)
        (ptr > 8'd3) |-> rd_data == '0);

    // R3
    dead_write_chk: assert property (@(posedge clk) disable iff (srst)
        (wr_en && (ptr == 8'd0 || ptr > 8'd3)) |=> $stable(pin_out) && $stable(pin_oe));

    // R9
    pol_write_chk: assert property (@(posedge clk) disable iff (srst)
        (wr_en && ptr == 8'd2) |=> $stable(pin_out) && $stable(pin_oe));
endmodule

bind gpx_bank gpx_bank_chk #(.W(W)) u_chk (
    .clk    (clk),
    .srst   (srst),
    .ptr    (ptr),
    .wr_en  (wr_en),
    .wr_data(wr_data),
    .rd_data(rd_data),
    .pin_out(pin_out),
    .pin_oe (pin_oe)
);

// File: tb/gpx_bank_tb.sv
module gpx_bank_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       srst = 1'b1;
    logic [7:0] ptr = 8'd0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] pin_in = 8'hFF;
    logic [7:0] rd_data, pin_out, pin_oe;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // behavioural reference state
    logic [7:0] m_out = 8'hFF, m_pol = 8'h00, m_dir = 8'hFF;
    logic [7:0] m_pins [$] = '{8'hFF, 8'hFF};

    always #(CLK_PERIOD/2) clk = ~clk;

    gpx_bank u_dut (
        .clk(clk), .srst(srst), .ptr(ptr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    always @(posedge clk) begin
        if (srst) begin
            m_out = 8'hFF; m_pol = 8'h00; m_dir = 8'hFF;
            m_pins = '{8'hFF, 8'hFF};
        end else begin
            if (wr_en) begin
                if (ptr == 8'd1) m_out = wr_data;
                else if (ptr == 8'd2) m_pol = wr_data;
                else if (ptr == 8'd3) m_dir = wr_data;
            end
            m_pins.push_back(pin_in);
            void'(m_pins.pop_front());
        end
    end

    function automatic logic [7:0] m_read(logic [7:0] p);
        case (p)
            8'd0: return m_pins[0] ^ m_pol;
            8'd1: return m_out;
            8'd2: return m_pol;
            8'd3: return m_dir;
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model, away from the clock edge
    always begin
        @(negedge clk);
        #2;
        if (!srst && !done) begin
            if (ptr == 8'd0)      check("R2 R6 R7 input read", rd_data, m_read(ptr));
            else if (ptr <= 8'd3) check("R4 R9 register read", rd_data, m_read(ptr));
            else                  check("R8 hole read", rd_data, m_read(ptr));
            check("R5 pin_out", pin_out, m_out);
            check("R5 pin_oe", pin_oe, ~m_dir);
        end
    end

    task automatic wr(logic [7:0] p, logic [7:0] d);
        @(negedge clk);
        ptr = p; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [7:0] p, int n);
        @(negedge clk);
        ptr = p; wr_en = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic peek(string req, logic [7:0] p, logic [7:0] exp);
        @(negedge clk);
        ptr = p; wr_en = 1'b0;
        #3;
        check(req, rd_data, exp);
    endtask

    task automatic finish_test();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected done");
        done = 1;
        finish_test();
    end

    initial begin
        repeat (3) @(negedge clk);
        srst = 1'b0;
        // R1 reset values
        peek("R1 out reset", 8'd1, 8'hFF);
        peek("R1 pol reset", 8'd2, 8'h00);
        peek("R1 dir reset", 8'd3, 8'hFF);
        peek("R1 input reset", 8'd0, 8'hFF);
        check("R1 pin_oe reset", pin_oe, 8'h00);
        check("R1 pin_out reset", pin_out, 8'hFF);

        // R7 latency: change pin and watch each cycle
        @(negedge clk); ptr = 8'd0; pin_in = 8'hA5;
        #3; check("R7 no change before edges", rd_data, 8'hFF);
        @(negedge clk); #3; check("R7 one edge", rd_data, 8'hFF);
        @(negedge clk); #3; check("R7 two edges", rd_data, 8'hA5);

        // R2 polarity on input read only
        wr(8'd2, 8'h0F);
        peek("R2 inverted read", 8'd0, 8'hAA);
        peek("R9 out unaffected", 8'd1, 8'hFF);

        // R3 write to input discarded
        wr(8'd0, 8'h00);
        peek("R3 input after write", 8'd0, 8'hAA);
        check("R3 pin_out kept", pin_out, 8'hFF);
        check("R3 pin_oe kept", pin_oe, 8'h00);

        // R4, R5 writes
        wr(8'd1, 8'h3C);
        wr(8'd3, 8'hF0);
        peek("R4 out readback", 8'd1, 8'h3C);
        peek("R4 dir readback", 8'd3, 8'hF0);
        check("R5 oe", pin_oe, 8'h0F);
        check("R5 out", pin_out, 8'h3C);

        // R6 driven pins still show external level
        wr(8'd3, 8'h00);
        wr(8'd2, 8'h00);
        @(negedge clk); pin_in = 8'hC3;
        rd(8'd0, 3);
        peek("R6 driven pin reads external", 8'd0, 8'hC3);
        wr(8'd2, 8'hFF);
        peek("R6 driven pin inverted", 8'd0, 8'h3C);

        // R8 out-of-range pointers
        wr(8'd4, 8'h00);
        wr(8'd255, 8'h55);
        peek("R8 ptr 4 read", 8'd4, 8'h00);
        peek("R8 ptr FF read", 8'd255, 8'h00);
        peek("R8 out kept", 8'd1, 8'h3C);
        peek("R8 pol kept", 8'd2, 8'hFF);
        peek("R8 dir kept", 8'd3, 8'h00);

        // walking pins through the synchroniser
        wr(8'd2, 8'h00);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); pin_in = 8'h01 << i;
            rd(8'd0, 2);
        end
        rd(8'd0, 2);

        // mid-run reset
        @(negedge clk); srst = 1'b1;
        @(negedge clk); srst = 1'b0;
        peek("R1 out after re-reset", 8'd1, 8'hFF);
        peek("R1 dir after re-reset", 8'd3, 8'hFF);
        rd(8'd0, 4);

        done = 1;
        finish_test();
    end
endmodule